// File: doc/BRIEF.md
# Package Sleep Ladder Sequencer

This block tracks how far a whole package has descended into its sleep hierarchy. Four active-low sideband levels request progressively deeper power states: stop-clock, sleep, deep sleep and deeper sleep. Two single-cycle strobes open and close a window for servicing a snoop while clocks are stopped. The sequencer is a strictly ordered ladder with six states: Normal, Stop Grant, Snoop Service, Sleep, Deep Sleep and Deeper Sleep. A state can be entered only from its neighbour on the ladder, and leaving it walks back one rung per clock.

The four sideband levels are asynchronous to the block clock. Each passes through a two-flop synchronizer before the ladder looks at it. The snoop strobes come from logic in the same clock domain and are used directly. The current state is presented as a one-hot vector. A separate flag marks residency in Deeper Sleep, which is the package state that backs the deepest core idle levels. The block has no data path, so every pin is a plain level or strobe with no handshake.

Top module: `pkg_sleep_ladder`

## Requirements
- R1: Reset, asynchronous and active low, puts the ladder in Normal with `deeper_active` low. `state_onehot` always has exactly one bit set, with this bit mapping: bit0 Normal, bit1 Stop Grant, bit2 Snoop Service, bit3 Sleep, bit4 Deep Sleep, bit5 Deeper Sleep.
- R2: In Normal, `stop_clk_n` low moves the ladder to Stop Grant. In Stop Grant, `stop_clk_n` high returns it to Normal.
- R3: A change on any of the four sideband pins takes effect at the third rising clock edge after the change. The two snoop strobes take effect at the first rising edge on which they are high.
- R4: In Stop Grant, `snoop_req` moves the ladder to Snoop Service. In Snoop Service, `snoop_done` returns it to Stop Grant. While in Snoop Service, all four sideband pins are ignored.
- R5: In Stop Grant, `sleep_n` low moves the ladder to Sleep. In Sleep, `sleep_n` high returns it to Stop Grant.
- R6: In Sleep, `deep_sleep_n` low moves the ladder to Deep Sleep. In Deep Sleep, `deep_sleep_n` high returns it to Sleep.
- R7: In Deep Sleep, `deeper_sleep_n` low moves the ladder to Deeper Sleep. In Deeper Sleep, `deeper_sleep_n` high returns it to Deep Sleep. `deeper_active` is high exactly while the ladder is in Deeper Sleep.
- R8: A pin or strobe that is not a legal next step for the current state is ignored. Examples are deep-sleep or deeper-sleep asserted in Stop Grant, and `snoop_req` outside Stop Grant. If such a pin is still asserted when its neighbouring state is reached, it takes effect on the next edge.
- R9: Releasing every pin while in Deeper Sleep walks the ladder down one state per clock: Deep Sleep, Sleep, Stop Grant, then Normal.
- R10: In Stop Grant, a stop-clock release takes priority over a snoop request, and a snoop request takes priority over sleep entry. In Sleep and Deep Sleep, the exit condition takes priority over entry to the next deeper state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_clk_n | input | 1 | Stop-clock request, active low, asynchronous |
| sleep_n | input | 1 | Sleep request, active low, asynchronous |
| deep_sleep_n | input | 1 | Deep-sleep request, active low, asynchronous |
| deeper_sleep_n | input | 1 | Deeper-sleep request, active low, asynchronous |
| snoop_req | input | 1 | One-cycle strobe: a snoop needs service |
| snoop_done | input | 1 | One-cycle strobe: the snoop has been serviced |
| state_onehot | output | 6 | Current ladder state, one-hot (mapping in R1) |
| deeper_active | output | 1 | High while in Deeper Sleep |

## Verification
In Stop Grant, a synchronized pin change and a snoop strobe can fall on the same clock edge. The bench provokes this by releasing `stop_clk_n` two negative edges before it raises `snoop_req` for one cycle, so that both reach the next-state logic at the same edge. The scoreboard expects Normal. It then repeats the collision with `sleep_n` falling instead, and expects Snoop Service. After `snoop_done` it expects Stop Grant, and one clock later Sleep, because the sleep request is still held.

// File: rtl/slp_ladder_pkg.sv
package slp_ladder_pkg;

  localparam int NUM_STATES = 6;
  localparam int NUM_PINS   = 4;
  localparam int STATE_W    = $clog2(NUM_STATES);

  // index of each sideband level inside the packed pin vector
  localparam int PIN_STOP   = 0;
  localparam int PIN_SLEEP  = 1;
  localparam int PIN_DEEP   = 2;
  localparam int PIN_DEEPER = 3;

  // encoding doubles as the one-hot bit position on the port
  typedef enum logic [STATE_W-1:0] {
    ST_NORMAL  = 3'd0,
    ST_STOPGNT = 3'd1,
    ST_SNOOP   = 3'd2,
    ST_SLEEP   = 3'd3,
    ST_DEEP    = 3'd4,
    ST_DEEPER  = 3'd5
  } slp_state_e;

endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/slp_next.sv
module slp_next
  import slp_ladder_pkg::*;
(
  input  slp_state_e          cur,
  input  logic [NUM_PINS-1:0] pins_n,
  input  logic                snoop_req,
  input  logic                snoop_done,
  output slp_state_e          nxt
);

  logic [NUM_PINS-1:0] want;
  assign want = ~pins_n;

  always_comb begin
    nxt = cur;
    case (cur)
      ST_NORMAL:  if (want[PIN_STOP]) nxt = ST_STOPGNT;
      ST_STOPGNT: begin
        if (!want[PIN_STOP])      nxt = ST_NORMAL;
        else if (snoop_req)       nxt = ST_SNOOP;
        else if (want[PIN_SLEEP]) nxt = ST_SLEEP;
      end
      ST_SNOOP:   if (snoop_done) nxt = ST_STOPGNT;
      ST_SLEEP: begin
        if (!want[PIN_SLEEP])     nxt = ST_STOPGNT;
        else if (want[PIN_DEEP])  nxt = ST_DEEP;
      end
      ST_DEEP: begin
        if (!want[PIN_DEEP])       nxt = ST_SLEEP;
        else if (want[PIN_DEEPER]) nxt = ST_DEEPER;
      end
      ST_DEEPER:  if (!want[PIN_DEEPER]) nxt = ST_DEEP;
      default:    nxt = ST_NORMAL;
    endcase
  end

endmodule

// File: rtl/slp_state_reg.sv
module slp_state_reg
  import slp_ladder_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  slp_state_e            nxt,
  output slp_state_e            cur,
  output logic [NUM_STATES-1:0] onehot,
  output logic                  deeper
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= ST_NORMAL;
    else        cur <= nxt;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_STATES; g++) begin : g_dec
      assign onehot[g] = (int'(cur) == g);
    end
  endgenerate

  assign deeper = onehot[int'(ST_DEEPER)];

endmodule

// File: rtl/pkg_sleep_ladder.sv
module pkg_sleep_ladder
  import slp_ladder_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_clk_n,
  input  logic       sleep_n,
  input  logic       deep_sleep_n,
  input  logic       deeper_sleep_n,
  input  logic       snoop_req,
  input  logic       snoop_done,
  output logic [5:0] state_onehot,
  output logic       deeper_active
);

  logic [NUM_PINS-1:0] pins_raw;
  logic [NUM_PINS-1:0] pins_sync;
  slp_state_e          cur;
  slp_state_e          nxt;

  assign pins_raw[PIN_STOP]   = stop_clk_n;
  assign pins_raw[PIN_SLEEP]  = sleep_n;
  assign pins_raw[PIN_DEEP]   = deep_sleep_n;
  assign pins_raw[PIN_DEEPER] = deeper_sleep_n;

  slp_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL('1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pins_raw),
    .q    (pins_sync)
  );

  slp_next u_next (
    .cur       (cur),
    .pins_n    (pins_sync),
    .snoop_req (snoop_req),
    .snoop_done(snoop_done),
    .nxt       (nxt)
  );

  slp_state_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .nxt   (nxt),
    .cur   (cur),
    .onehot(state_onehot),
    .deeper(deeper_active)
  );

endmodule

// File: rtl/slp_ladder_chk.sv
module slp_ladder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       snoop_req,
  input logic       snoop_done,
  input logic [5:0] state_onehot,
  input logic       deeper_active
);

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_onehot) == 1);

  assert_normal_from_stopgnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_onehot[0]) |-> $past(state_onehot[1]));

  assert_snoop_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_onehot[2]) |-> $past(state_onehot[1] && snoop_req));

  assert_snoop_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(state_onehot[2]) |-> ($past(snoop_done) && state_onehot[1]));

  assert_sleep_neighbour_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_onehot[3]) |-> $past(state_onehot[1] || state_onehot[4]));

  assert_deep_neighbour_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_onehot[4]) |-> $past(state_onehot[3] || state_onehot[5]));

  assert_deeper_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deeper_active) |-> $past(state_onehot[4]));

  assert_stopgnt_neighbour_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_onehot[1]) |-> $past(state_onehot[0] || state_onehot[2] || state_onehot[3]));

endmodule

bind pkg_sleep_ladder slp_ladder_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .snoop_req    (snoop_req),
  .snoop_done   (snoop_done),
  .state_onehot (state_onehot),
  .deeper_active(deeper_active)
);

// File: tb/pkg_sleep_ladder_tb.sv
`timescale 1ns/1ps
module pkg_sleep_ladder_tb;

  localparam logic [5:0] OH_NORM = 6'b000001;
  localparam logic [5:0] OH_SG   = 6'b000010;
  localparam logic [5:0] OH_SNP  = 6'b000100;
  localparam logic [5:0] OH_SLP  = 6'b001000;
  localparam logic [5:0] OH_DEEP = 6'b010000;
  localparam logic [5:0] OH_DPR  = 6'b100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_clk_n = 1'b1, sleep_n = 1'b1, deep_sleep_n = 1'b1, deeper_sleep_n = 1'b1;
  logic snoop_req = 1'b0, snoop_done = 1'b0;
  logic [5:0] state_onehot;
  logic deeper_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [5:0] oh;
    logic       dp;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  event chk_ev;

  always #5 clk = ~clk;

  pkg_sleep_ladder u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_clk_n    (stop_clk_n),
    .sleep_n       (sleep_n),
    .deep_sleep_n  (deep_sleep_n),
    .deeper_sleep_n(deeper_sleep_n),
    .snoop_req     (snoop_req),
    .snoop_done    (snoop_done),
    .state_onehot  (state_onehot),
    .deeper_active (deeper_active)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(input logic [5:0] oh, input string tag);
    exp_t e;
    e.oh  = oh;
    e.dp  = (oh == OH_DPR);
    e.tag = tag;
    sb_q.push_back(e);
    -> chk_ev;
  endtask

  task automatic pulse_req();
    snoop_req = 1'b1; tick(1); snoop_req = 1'b0;
  endtask

  task automatic pulse_done();
    snoop_done = 1'b1; tick(1); snoop_done = 1'b0;
  endtask

  // monitor: compares the outputs with every queued expectation
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (state_onehot !== e.oh || deeper_active !== e.dp) begin
          errors++;
          $display("FAIL %s: got oh=%b dp=%b, expected oh=%b dp=%b",
                   e.tag, state_onehot, deeper_active, e.oh, e.dp);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(2);
    expect_st(OH_NORM, "R1 reset state");
    rst_n = 1'b1;
    tick(2);
    expect_st(OH_NORM, "R1 idle after reset");

    // R2/R3: stop-clock entry three edges after the pin change
    stop_clk_n = 1'b0; tick(2);
    expect_st(OH_NORM, "R3 not yet through synchronizer");
    tick(1);
    expect_st(OH_SG, "R2 enter stop grant");

    // R8: non-adjacent requests are ignored in stop grant
    deep_sleep_n = 1'b0; deeper_sleep_n = 1'b0; tick(3);
    expect_st(OH_SG, "R8 deep/deeper ignored in stop grant");

    // R4: snoop detour; pins ignored while servicing
    pulse_req();
    expect_st(OH_SNP, "R4 snoop entry");
    stop_clk_n = 1'b1; tick(3);
    expect_st(OH_SNP, "R4 stop release ignored during snoop");
    pulse_done();
    expect_st(OH_SG, "R4 snoop exit");
    tick(1);
    expect_st(OH_NORM, "R2 held release returns to normal");
    pulse_req();
    expect_st(OH_NORM, "R8 snoop request ignored in normal");
    stop_clk_n = 1'b0; tick(3);
    expect_st(OH_SG, "R2 re-enter stop grant");

    // R5/R6/R7/R8: sleep entry cascades through held requests
    sleep_n = 1'b0; tick(3);
    expect_st(OH_SLP, "R5 enter sleep");
    tick(1);
    expect_st(OH_DEEP, "R6 held deep request acts next edge");
    tick(1);
    expect_st(OH_DPR, "R7 held deeper request acts next edge");

    deeper_sleep_n = 1'b1; tick(3);
    expect_st(OH_DEEP, "R7 deeper release");
    deeper_sleep_n = 1'b0; tick(3);
    expect_st(OH_DPR, "R7 deeper re-entry");
    pulse_req();
    expect_st(OH_DPR, "R8 snoop request ignored in deeper");

    // R9: release everything, one level per clock
    stop_clk_n = 1'b1; sleep_n = 1'b1; deep_sleep_n = 1'b1; deeper_sleep_n = 1'b1;
    tick(3);
    expect_st(OH_DEEP, "R9 walk step deep");
    tick(1);
    expect_st(OH_SLP, "R9 walk step sleep");
    tick(1);
    expect_st(OH_SG, "R9 walk step stop grant");
    tick(1);
    expect_st(OH_NORM, "R9 walk step normal");

    // R10: stop release and snoop request on the same edge
    stop_clk_n = 1'b0; tick(3);
    expect_st(OH_SG, "R2 stop grant before collision");
    stop_clk_n = 1'b1; tick(2);
    pulse_req();
    expect_st(OH_NORM, "R10 stop release beats snoop request");

    // R10: sleep entry and snoop request on the same edge
    stop_clk_n = 1'b0; tick(3);
    sleep_n = 1'b0; tick(2);
    pulse_req();
    expect_st(OH_SNP, "R10 snoop beats sleep entry");
    pulse_done();
    expect_st(OH_SG, "R4 back to stop grant");
    tick(1);
    expect_st(OH_SLP, "R5 held sleep request after snoop");

    // R10: in sleep, exit wins over deep entry on the same edge
    sleep_n = 1'b1; deep_sleep_n = 1'b0; tick(3);
    expect_st(OH_SG, "R10 sleep exit beats deep entry");

    // R5: release sleep path fully
    deep_sleep_n = 1'b1; tick(3);
    expect_st(OH_SG, "R5 stays in stop grant");

    // R1: reset in the middle of operation
    rst_n = 1'b0; tick(1);
    expect_st(OH_NORM, "R1 mid-run reset");

    #1;
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule